// File: doc/BRIEF.md
# Single-Bin Phase Correlator

This block measures the phase of a sampled tone. It correlates the incoming samples against one stored cycle of sine and cosine. Each valid sample is multiplied by the reference entry at the current position in the cycle. The products go into two accumulators: the in-phase sum uses cosine and the quadrature sum uses sine.

After exactly one reference cycle of valid samples, the block dumps both sums into output registers and raises a one-clock strobe. The next window starts on the very next valid sample, so no sample is lost between windows. The reference position and the window boundary come from the same counter, which keeps them aligned.

With 100 table entries and a tone sampled 100 times per period, the block produces one I/Q pair per signal period. An arctangent stage downstream turns that pair into a phase.

Top module: `dft_bin_correlator`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the reference position, both accumulators, `out_i`, `out_q` and `out_valid` to zero.
- R2: The reference position starts at 0, advances by one on each clock with `in_valid` high, and wraps from N_PTS-1 (99 by default) back to 0.
- R3: The reference entry at position k is round(32767·sin(2πk/N_PTS)) for the sine table and round(32767·cos(2πk/N_PTS)) for the cosine table. Halves round away from zero, and both tables are 16-bit two's complement.
- R4: A window covers N_PTS consecutive valid samples. `out_i` equals the sum of sample·cos[k] over that window and `out_q` equals the sum of sample·sin[k], where k is the sample's position in the window. Samples are 16-bit signed and no carry-in term is added.
- R5: The first product of a window replaces the accumulator contents. Windows therefore follow each other back to back, with no idle cycle between them.
- R6: `out_valid` is high for exactly one clock, on the cycle after the rising edge that took the window's last sample. `out_i` and `out_q` carry that window's sums in that same cycle.
- R7: Between strobes, `out_i` and `out_q` keep their last values.
- R8: A cycle with `in_valid` low changes neither the reference position nor the accumulators. The sample present during such a cycle is not counted in any sum.
- R9: The 40-bit signed sums are exact for full-scale samples, including a window where every sample is -32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` this cycle |
| in_sample | input | 16 | Signed input sample |
| out_i | output | 40 | Signed in-phase window sum |
| out_q | output | 40 | Signed quadrature window sum |
| out_valid | output | 1 | One-clock strobe marking a new result pair |

## Verification
The assertions assume that `in_valid` and `in_sample` are driven to known values on every clock after reset, and that `rst` is high from time zero until at least the first clock edge. They make no assumption about how often `in_valid` is high, how long it stays low, or what the sample is during an invalid cycle.

The stimulus changes inputs only on falling edges. It holds reset from power-up. It then mixes randomly gated valid cycles with garbage samples during the gaps, unbroken full-scale windows, and a reset arriving in the middle of a window, so every assumed input pattern is visited while staying inside those limits.

// File: rtl/dft_pkg.sv
package dft_pkg;

  localparam int    DEF_N_PTS  = 100;
  localparam int    DEF_SAMP_W = 16;
  localparam int    DEF_COEF_W = 16;
  localparam int    DEF_ACC_W  = 40;
  localparam real   TWO_PI     = 6.283185307179586;
  localparam real   REF_AMP    = 32767.0;

  // Reference entry k of an n-point cycle; rounding moves halves away from zero.
  function automatic int ref_entry(input int k, input int n, input bit use_cos);
    real ang;
    real v;
    int  r;
    ang = TWO_PI * real'(k) / real'(n);
    v   = REF_AMP * (use_cos ? $cos(ang) : $sin(ang));
    if (v >= 0.0) r = $rtoi(v + 0.5);
    else          r = -$rtoi(0.5 - v);
    return r;
  endfunction

  // Next accumulator value: a window's first product loads, later ones add.
  function automatic logic signed [DEF_ACC_W-1:0] mac_next(
      input logic signed [DEF_ACC_W-1:0] acc,
      input logic signed [DEF_ACC_W-1:0] prod,
      input logic                        first);
    return first ? prod : acc + prod;
  endfunction

endpackage

// File: rtl/dft_ref_rom.sv
module dft_ref_rom #(
  parameter int N_PTS  = dft_pkg::DEF_N_PTS,
  parameter int COEF_W = dft_pkg::DEF_COEF_W,
  parameter bit USE_COS = 1'b0,
  localparam int IDX_W = $clog2(N_PTS)
) (
  input  logic [IDX_W-1:0]         idx,
  output logic signed [COEF_W-1:0] coef
);

  logic signed [COEF_W-1:0] tab [N_PTS];

  for (genvar k = 0; k < N_PTS; k++) begin : g_entry
    localparam int VAL = dft_pkg::ref_entry(k, N_PTS, USE_COS);
    assign tab[k] = COEF_W'(VAL);
  end

  always_comb begin
    coef = '0;
    for (int k = 0; k < N_PTS; k++) begin
      if (idx == IDX_W'(k)) coef = tab[k];
    end
  end

endmodule

// File: rtl/dft_phase_ctr.sv
module dft_phase_ctr #(
  parameter int N_PTS = dft_pkg::DEF_N_PTS,
  localparam int IDX_W = $clog2(N_PTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             at_first,
  output logic             at_last
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PTS - 1);

  assign at_first = (idx == '0);
  assign at_last  = (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (adv)     idx <= at_last ? '0 : idx + 1'b1;
  end

endmodule

// File: rtl/dft_mac_lane.sv
module dft_mac_lane #(
  parameter int SAMP_W = dft_pkg::DEF_SAMP_W,
  parameter int COEF_W = dft_pkg::DEF_COEF_W,
  parameter int ACC_W  = dft_pkg::DEF_ACC_W,
  localparam int PROD_W = SAMP_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic                     first,
  input  logic signed [SAMP_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  acc,
  output logic signed [ACC_W-1:0]  sum_next
);

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;

  assign prod     = sample * coef;
  assign prod_ext = ACC_W'(prod);
  assign sum_next = dft_pkg::mac_next(acc, prod_ext, first);

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (take) acc <= sum_next;
  end

endmodule

// File: rtl/dft_bin_correlator.sv
module dft_bin_correlator #(
  parameter int N_PTS  = dft_pkg::DEF_N_PTS,
  parameter int SAMP_W = dft_pkg::DEF_SAMP_W,
  parameter int COEF_W = dft_pkg::DEF_COEF_W,
  parameter int ACC_W  = dft_pkg::DEF_ACC_W,
  localparam int IDX_W = $clog2(N_PTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [SAMP_W-1:0] in_sample,
  output logic signed [ACC_W-1:0]  out_i,
  output logic signed [ACC_W-1:0]  out_q,
  output logic                     out_valid
);

  logic [IDX_W-1:0] idx;
  logic             at_first;
  logic             at_last;
  logic             dump;

  logic signed [COEF_W-1:0] coef [2];
  logic signed [ACC_W-1:0]  acc  [2];
  logic signed [ACC_W-1:0]  sum  [2];

  dft_phase_ctr #(.N_PTS(N_PTS)) u_ctr (
    .clk(clk), .rst(rst), .adv(in_valid),
    .idx(idx), .at_first(at_first), .at_last(at_last)
  );

  assign dump = in_valid & at_last;

  // lane 0: in-phase (cosine), lane 1: quadrature (sine)
  for (genvar l = 0; l < 2; l++) begin : g_lane
    dft_ref_rom #(.N_PTS(N_PTS), .COEF_W(COEF_W), .USE_COS(l == 0)) u_rom (
      .idx(idx), .coef(coef[l])
    );
    dft_mac_lane #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
      .clk(clk), .rst(rst), .take(in_valid), .first(at_first),
      .sample(in_sample), .coef(coef[l]), .acc(acc[l]), .sum_next(sum[l])
    );
  end

  logic signed [ACC_W-1:0] acc_i;
  logic signed [ACC_W-1:0] acc_q;
  assign acc_i = acc[0];
  assign acc_q = acc[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_i     <= '0;
      out_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= dump;
      if (dump) begin
        out_i <= sum[0];
        out_q <= sum[1];
      end
    end
  end

endmodule

// File: rtl/dft_bin_checker.sv
module dft_bin_checker #(
  parameter int N_PTS = 100,
  parameter int IDX_W = 7,
  parameter int ACC_W = 40
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [IDX_W-1:0]        idx,
  input logic                    dump,
  input logic signed [ACC_W-1:0] acc_i,
  input logic signed [ACC_W-1:0] acc_q,
  input logic signed [ACC_W-1:0] out_i,
  input logic signed [ACC_W-1:0] out_q,
  input logic                    out_valid
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (idx == '0 && acc_i == '0 && acc_q == '0 && !out_valid && out_i == '0 && out_q == '0));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx < IDX_W'(N_PTS));

  // R2
  idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && idx == IDX_W'(N_PTS - 1)) |=> idx == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(idx) && $stable(acc_i) && $stable(acc_q)));

  // R6
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dump |=> out_valid);

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dump |=> ($stable(out_i) && $stable(out_q)));

endmodule

bind dft_bin_correlator dft_bin_checker #(.N_PTS(N_PTS), .IDX_W(IDX_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .idx(idx), .dump(dump),
  .acc_i(acc_i), .acc_q(acc_q), .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
);

// File: tb/tb_dft_bin_correlator.sv
module tb_dft_bin_correlator;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 100;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic signed [39:0] out_i, out_q;
  logic               out_valid;

  int errors = 0;
  int checks = 0;

  int     m_idx = 0;
  longint m_acc_i = 0, m_acc_q = 0, m_out_i = 0, m_out_q = 0;
  bit     m_out_v = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dft_bin_correlator dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  // R3: round half up through floor, equal to the rule except at exact halves
  function automatic longint ref_val(input int k, input bit use_cos);
    real a;
    real v;
    a = 2.0 * 3.141592653589793 * k / NP;
    v = 32767.0 * (use_cos ? $cos(a) : $sin(a));
    return longint'($floor(v + 0.5));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Check the outputs of the last edge, then drive and advance the model one edge.
  task automatic cyc(input bit r, input bit v, input logic signed [15:0] s);
    chk(out_valid == m_out_v, "R6 strobe", longint'(out_valid), longint'(m_out_v));
    chk(out_i == m_out_i, m_out_v ? "R4 I sum" : "R7 I hold", out_i, m_out_i);
    chk(out_q == m_out_q, m_out_v ? "R4 Q sum" : "R7 Q hold", out_q, m_out_q);
    rst = r; in_valid = v; in_sample = s;
    if (r) begin
      m_idx = 0; m_acc_i = 0; m_acc_q = 0; m_out_i = 0; m_out_q = 0; m_out_v = 0;
    end else begin
      m_out_v = 0;
      if (v) begin
        longint pi_, pq;
        pi_ = longint'(s) * ref_val(m_idx, 1'b1);
        pq  = longint'(s) * ref_val(m_idx, 1'b0);
        // R5: first product of a window loads
        m_acc_i = (m_idx == 0) ? pi_ : m_acc_i + pi_;
        m_acc_q = (m_idx == 0) ? pq  : m_acc_q + pq;
        if (m_idx == NP - 1) begin
          m_out_i = m_acc_i; m_out_q = m_acc_q; m_out_v = 1; m_idx = 0;
        end else m_idx++;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(out_i == 0 && out_q == 0 && !out_valid, "R1 reset", out_i, 0);
    cyc(1'b0, 1'b0, 16'sd0);
    // R2/R5: back-to-back windows with valid every cycle
    for (int n = 0; n < 3 * NP; n++) cyc(1'b0, 1'b1, 16'($urandom));
    // R8: gated valid, garbage on idle cycles
    for (int n = 0; n < 12 * NP; n++) begin
      bit v;
      v = ($urandom % 4) != 0;
      cyc(1'b0, v, 16'($urandom));
    end
    // R9: full-scale negative, then positive
    for (int n = 0; n < NP; n++) cyc(1'b0, 1'b1, -16'sd32768);
    for (int n = 0; n < NP; n++) cyc(1'b0, 1'b1, 16'sd32767);
    // R3: unit impulse at one table position
    for (int n = 0; n < NP; n++) cyc(1'b0, 1'b1, (n == 13) ? 16'sd1 : 16'sd0);
    // R1: reset mid-window, then a clean window
    for (int n = 0; n < 37; n++) cyc(1'b0, 1'b1, 16'($urandom));
    cyc(1'b1, 1'b1, 16'sd1234);
    for (int n = 0; n < 2 * NP + 5; n++) cyc(1'b0, ($urandom % 8) != 0, 16'($urandom));
    cyc(1'b0, 1'b0, 16'sd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule